// File: doc/BRIEF.md
# Multi-Mode 16-bit Event Timer

The block is a 16-bit up-counter that advances on cycles where a count-enable input is high, compared every such cycle against two compare registers. A control register picks one of four behaviours: halted with the count held at zero, free-running with wrap-around, restart from zero on a rising edge of an external event input, or restart from zero when the count meets compare register 0. Each compare hit raises a one-cycle interrupt and toggles a single output pin. A control bit lets a qualified event edge toggle that pin as well.

Software loads the control register and the two compare values through a single-cycle write port. Control fields other than the overflow bit are locked while the timer runs; the only change accepted then is a return to the halted behaviour. A sticky overflow bit records every transition of the count from all-ones to zero. The event input is asynchronous and passes through a flop synchronizer before edge detection. A parameter removes the edge-toggle option for instances where it must not be used.

Top module: `evt_timer16`

## Requirements
- R1: After reset the count, output pin, interrupt and control register all read 0, so the timer starts halted.
- R2: While the mode field (control bits [3:2]) is 00, the count is held at 0, the output pin keeps its value and no interrupt is raised, even when the count equals a compare value.
- R3: A write to address 0 loads the control register (bits [3:2] mode, bit [1] toggle source, bit [0] overflow). A write to address 1 loads compare register 0, and a write to address 2 loads compare register 1. Compare registers accept writes at any time. While the timer is halted, all control bits accept writes.
- R4: In mode 01 the count rises by one on each clock edge where count enable was high, holds otherwise, and wraps from FFFFH to 0000H.
- R5: In any running mode, an enabled cycle whose count equals either compare value gives a one-cycle interrupt and one toggle of the output pin on the following cycle. An interrupt never follows a cycle with count enable low.
- R6: In mode 11, an enabled cycle whose count equals compare register 0 loads 0000H instead of incrementing.
- R7: The overflow bit is set when the count changes from FFFFH to 0000H in a running mode, including mode 11 with compare register 0 at FFFFH. It stays set until software writes bit [0] = 0, and that write is accepted while running.
- R8: In mode 10, a rising edge of the event input clears the count three clocks after the edge is first sampled. Each edge clears the count once, even if the input stays high, and an event edge raises no interrupt.
- R9: While running, a control write whose mode field is not 00 leaves bits [3:1] unchanged. A write with mode field 00 halts the timer and leaves bit [1] unchanged.
- R10: With bit [1] = 1, a qualified event edge also toggles the output pin. Any combination of compare hits and an edge in one cycle toggles the pin once and gives one interrupt cycle.
- R11: With the edge-toggle parameter at 0, bit [1] has no effect and event edges never toggle the output pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable, one advance per high cycle |
| evt_i | input | 1 | Asynchronous event input |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 control, 1 compare 0, 2 compare 1 |
| wr_data_i | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Current count |
| tout_o | output | 1 | Toggle output pin |
| irq_o | output | 1 | Match interrupt pulse |
| ctrl_o | output | 4 | Control register contents |

## Verification
The bench drives the default 16-bit build and a second copy with the edge-toggle parameter at 0 from the same stimulus. It compares the two output pins around each event edge, so R11 is checked against the enabled variant. Because the default width is kept, both full wraps are run: the free-running one and the one in mode 11 with compare register 0 at FFFFH. Each wrap takes 65536 enabled cycles, which lets the bench observe the overflow rule at the real boundary and not at a reduced width.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;
  typedef enum logic [1:0] {
    MODE_STOP  = 2'b00,
    MODE_FREE  = 2'b01,
    MODE_EDGE  = 2'b10,
    MODE_MATCH = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    tmr_mode_e mode;
    logic      tsel;
    logic      ovf;
  } tmr_ctrl_t;

  localparam int unsigned REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_CMP0 = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_CMP1 = 2'd2;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], evt_i};
  end

  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its delayed copy
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import evt_timer16_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]      wr_data_i,
  input  logic                  ovf_set_i,
  output tmr_ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]      cmp0_o,
  output logic [CNT_W-1:0]      cmp1_o
);
  tmr_ctrl_t ctrl_q;
  logic      running;
  logic      wr_ctrl;
  tmr_mode_e wr_mode;

  assign running = (ctrl_q.mode != MODE_STOP);
  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_mode = tmr_mode_e'(wr_data_i[3:2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cmp0_o <= '0;
      cmp1_o <= '0;
    end else begin
      if (wr_ctrl) begin
        if (!running) begin
          ctrl_q.mode <= wr_mode;
          ctrl_q.tsel <= wr_data_i[1];
        end else if (wr_mode == MODE_STOP) begin
          ctrl_q.mode <= MODE_STOP;
        end
      end
      // hardware set wins over a same-cycle software clear
      ctrl_q.ovf <= ovf_set_i | (wr_ctrl ? wr_data_i[0] : ctrl_q.ovf);
      if (wr_en_i && wr_addr_i == ADDR_CMP0) cmp0_o <= wr_data_i;
      if (wr_en_i && wr_addr_i == ADDR_CMP1) cmp1_o <= wr_data_i;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import evt_timer16_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter bit          EDGE_TOG_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             edge_i,
  input  tmr_mode_e        mode_i,
  input  logic             tsel_i,
  input  logic [CNT_W-1:0] cmp0_i,
  input  logic [CNT_W-1:0] cmp1_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tout_o,
  output logic             irq_o,
  output logic             ovf_set_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             running, hit0, hit1, edge_tog;

  assign running = (mode_i != MODE_STOP);
  assign hit0    = cnt_en_i && (cnt_q == cmp0_i);
  assign hit1    = cnt_en_i && (cnt_q == cmp1_i);
  assign cnt_inc = cnt_en_i ? cnt_q + CNT_ONE : cnt_q;

  generate
    if (EDGE_TOG_EN) begin : g_edge_tog
      assign edge_tog = tsel_i && edge_i;
    end else begin : g_no_edge_tog
      assign edge_tog = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (mode_i)
      MODE_STOP:  cnt_d = '0;
      MODE_FREE:  cnt_d = cnt_inc;
      MODE_EDGE:  cnt_d = edge_i ? '0 : cnt_inc;
      MODE_MATCH: cnt_d = hit0 ? '0 : cnt_inc;
      default:    cnt_d = '0;
    endcase
  end

  assign ovf_set_o = running && (cnt_q == '1) && (cnt_d == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tout_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_o <= running && (hit0 || hit1);
      if (running && (hit0 || hit1 || edge_tog)) tout_o <= ~tout_o;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer16_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          EDGE_TOG_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             evt_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tout_o,
  output logic             irq_o,
  output logic [3:0]       ctrl_o
);
  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] cmp0_q, cmp1_q;
  logic             evt_rise, ovf_set;

  evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_i),
    .rise_o(evt_rise)
  );

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .ovf_set_i(ovf_set),
    .ctrl_o   (ctrl_q),
    .cmp0_o   (cmp0_q),
    .cmp1_o   (cmp1_q)
  );

  tmr_core #(.CNT_W(CNT_W), .EDGE_TOG_EN(EDGE_TOG_EN)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_en_i (cnt_en_i),
    .edge_i   (evt_rise),
    .mode_i   (ctrl_q.mode),
    .tsel_i   (ctrl_q.tsel),
    .cmp0_i   (cmp0_q),
    .cmp1_i   (cmp1_q),
    .cnt_o    (cnt_o),
    .tout_o   (tout_o),
    .irq_o    (irq_o),
    .ovf_set_o(ovf_set)
  );

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_en_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [1:0]       wr_mode_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             tout_o,
  input logic             irq_o,
  input logic [3:0]       ctrl_o,
  input logic [CNT_W-1:0] cmp0
);
  logic wr_ctrl;
  assign wr_ctrl = wr_en_i && (wr_addr_i == 2'd0);

  assert_stop_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[3:2] == 2'b00 |=> cnt_o == '0);

  assert_stop_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[3:2] == 2'b00 |=> (!irq_o && $stable(tout_o)));

  assert_free_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[3:2] == 2'b01 && !cnt_en_i) |=> $stable(cnt_o));

  assert_irq_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(cnt_en_i));

  assert_match_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[3:2] == 2'b11 && cnt_en_i && cnt_o == cmp0) |=> cnt_o == '0);

  assert_ovf_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ctrl_o[0]) && !$past(wr_ctrl)) |-> ($past(cnt_o) == '1 && cnt_o == '0));

  assert_run_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[3:2] != 2'b00 && wr_ctrl && wr_mode_i != 2'b00) |=> ctrl_o[3:1] == $past(ctrl_o[3:1]));
endmodule

bind evt_timer16 evt_timer16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_en_i (cnt_en_i),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_mode_i(wr_data_i[3:2]),
  .cnt_o    (cnt_o),
  .tout_o   (tout_o),
  .irq_o    (irq_o),
  .ctrl_o   (ctrl_o),
  .cmp0     (cmp0_q)
);

// File: tb/evt_timer16_test.sv
`timescale 1ns/1ps
module evt_timer16_test;
  localparam int SIG_CNT = 0, SIG_TOUT = 1, SIG_IRQ = 2, SIG_CTRL = 3, SIG_NTOUT = 4, SIG_NCNT = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, evt = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt, n_cnt;
  logic        tout, irq, n_tout, n_irq;
  logic [3:0]  ctrl, n_ctrl;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct { string req; int sig; logic [15:0] exp; } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  evt_timer16 uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .evt_i(evt),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cnt_o(cnt), .tout_o(tout), .irq_o(irq), .ctrl_o(ctrl));

  evt_timer16 #(.EDGE_TOG_EN(1'b0)) uut_noedge (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .evt_i(evt),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cnt_o(n_cnt), .tout_o(n_tout), .irq_o(n_irq), .ctrl_o(n_ctrl));

  function automatic logic [15:0] observe(int sig);
    case (sig)
      SIG_CNT:   return cnt;
      SIG_TOUT:  return {15'd0, tout};
      SIG_IRQ:   return {15'd0, irq};
      SIG_CTRL:  return {12'd0, ctrl};
      SIG_NTOUT: return {15'd0, n_tout};
      default:   return n_cnt;
    endcase
  endfunction

  // monitor: drains the scoreboard just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb_q.pop_front();
        act = observe(it.sig);
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s sig=%0d actual=%h expected=%h t=%0t", it.req, it.sig, act, it.exp, $time);
        end
      end
    end
  end

  task automatic expect_val(string req, int sig, logic [15:0] e);
    item_t it;
    it.req = req; it.sig = sig; it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(logic [15:0] target);
    int n = 0;
    while (cnt !== target && n < 70000) begin
      step(1);
      n++;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic tv, tvn;
    step(3);
    expect_val("R1", SIG_CNT, 16'h0);
    expect_val("R1", SIG_TOUT, 16'h0);
    expect_val("R1", SIG_IRQ, 16'h0);
    expect_val("R1", SIG_CTRL, 16'h0);
    rst_n = 1'b1; cnt_en = 1'b1;
    step(3);
    expect_val("R2", SIG_CNT, 16'h0);

    // free-running, cmp0=5 cmp1=3
    wr(2'd1, 16'd5); wr(2'd2, 16'd3); wr(2'd0, 16'h4);
    expect_val("R3", SIG_CTRL, 16'h4);
    expect_val("R2", SIG_CNT, 16'h0);
    for (int k = 1; k <= 7; k++) begin
      step(1);
      expect_val("R4", SIG_CNT, 16'(k));
      expect_val("R5", SIG_IRQ, (k == 4 || k == 6) ? 16'h1 : 16'h0);
      expect_val("R5", SIG_TOUT, (k == 4 || k == 5) ? 16'h1 : 16'h0);
    end
    cnt_en = 1'b0;
    step(3);
    expect_val("R4", SIG_CNT, 16'd7);
    expect_val("R5", SIG_IRQ, 16'h0);
    cnt_en = 1'b1;

    wr(2'd0, 16'hE);
    expect_val("R9", SIG_CTRL, 16'h4);

    wait_cnt(16'hFFFF);
    expect_val("R7", SIG_CTRL, 16'h4);
    step(1);
    expect_val("R4", SIG_CNT, 16'h0);
    expect_val("R7", SIG_CTRL, 16'h5);
    step(3);
    expect_val("R7", SIG_CTRL, 16'h5);
    wr(2'd0, 16'h4);
    expect_val("R7", SIG_CTRL, 16'h4);

    wr(2'd0, 16'h0);
    expect_val("R9", SIG_CTRL, 16'h0);
    step(1);
    expect_val("R2", SIG_CNT, 16'h0);
    wr(2'd2, 16'd0);
    tv = tout;
    step(3);
    expect_val("R2", SIG_IRQ, 16'h0);
    expect_val("R2", SIG_TOUT, {15'd0, tv});

    // clear on compare 0: cmp0=4 cmp1=2
    wr(2'd1, 16'd4); wr(2'd2, 16'd2); wr(2'd0, 16'hC);
    expect_val("R3", SIG_CTRL, 16'hC);
    tv = tout;
    for (int k = 1; k <= 6; k++) begin
      step(1);
      expect_val("R6", SIG_CNT, (k == 5) ? 16'd0 : (k == 6) ? 16'd1 : 16'(k));
      expect_val("R5", SIG_IRQ, (k == 3 || k == 5) ? 16'h1 : 16'h0);
      expect_val("R5", SIG_TOUT, {15'd0, (k == 3 || k == 4) ? ~tv : tv});
    end
    wr(2'd0, 16'h0);

    // coincident compare hits and event edge, free-running, edge toggle on
    wr(2'd1, 16'd6); wr(2'd2, 16'd6); wr(2'd0, 16'h6);
    tv = tout; tvn = n_tout;
    step(4);
    evt = 1'b1;
    step(3);
    expect_val("R10", SIG_CNT, 16'd7);
    expect_val("R10", SIG_IRQ, 16'h1);
    expect_val("R10", SIG_TOUT, {15'd0, ~tv});
    expect_val("R11", SIG_NTOUT, {15'd0, ~tvn});
    step(1);
    expect_val("R10", SIG_IRQ, 16'h0);
    expect_val("R10", SIG_TOUT, {15'd0, ~tv});
    expect_val("R10", SIG_CNT, 16'd8);
    evt = 1'b0;
    wr(2'd0, 16'h0);

    // edge clear mode, edge toggle on
    wr(2'd1, 16'hFFF0); wr(2'd2, 16'hFFF1); wr(2'd0, 16'hA);
    step(5);
    expect_val("R8", SIG_CNT, 16'd5);
    tv = tout; tvn = n_tout;
    evt = 1'b1;
    step(2);
    expect_val("R8", SIG_CNT, 16'd7);
    expect_val("R10", SIG_TOUT, {15'd0, tv});
    step(1);
    expect_val("R8", SIG_CNT, 16'd0);
    expect_val("R8", SIG_IRQ, 16'h0);
    expect_val("R10", SIG_TOUT, {15'd0, ~tv});
    expect_val("R11", SIG_NTOUT, {15'd0, tvn});
    expect_val("R11", SIG_NCNT, 16'd0);
    step(2);
    expect_val("R8", SIG_CNT, 16'd2);
    expect_val("R10", SIG_TOUT, {15'd0, ~tv});
    evt = 1'b0;
    step(2);

    // clear on compare 0 at all-ones still flags overflow
    wr(2'd0, 16'h0); wr(2'd1, 16'hFFFF); wr(2'd2, 16'h0010); wr(2'd0, 16'hC);
    wait_cnt(16'hFFFF);
    expect_val("R7", SIG_CTRL, 16'hC);
    step(1);
    expect_val("R6", SIG_CNT, 16'h0);
    expect_val("R7", SIG_CTRL, 16'hD);

    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule